// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line Error Flags

This block turns an asynchronous serial line back into data words. A one-cycle enable that pulses sixteen times per bit period drives its timing. The line input first passes through a synchronizer. A falling edge on the idle line starts a candidate frame, and the receiver takes its timing from that edge. Every later bit is sampled near its centre. Start, parity and stop bits are removed, so only the data word, right-justified to the configured length, reaches the host side.

Each received word goes into a single holding register, where it is marked ready. A parity error, framing error or break in that word sets a matching error flag. A line held at space for more than a whole frame is reported as a break, not as a framing error, and loads one zero word. A word that arrives while the previous one has not yet been read sets an overrun flag and replaces the older word. The host clears the ready bit with a data-read strobe. It clears all four error flags with a status-read strobe.

Top module: `serial_rx`

## Requirements
- R1: The line input is synchronized to the clock and starts at mark (1). A frame begins only on a 1-to-0 transition of the synchronized line, and the oversample counter restarts on that transition.
- R2: The start bit is checked again on the 8th enable pulse after the edge (half a bit). If the line reads 1 at that point, the receiver goes back to idle and delivers nothing.
- R3: Data bits are sampled every 16 enable pulses after the start check and are taken least significant bit first. `cfg_len` selects the data length as 5 + `cfg_len` bits (0 gives 5, 3 gives 8). `rx_data` is right-justified, and its unused upper bits read 0.
- R4: With `cfg_par_en`=1 one parity bit follows the data and is compared with the expected value. The expected value makes the total number of ones even when `cfg_par_even`=1 and odd when it is 0. With `cfg_par_stick`=1 the expected bit is instead fixed at 0 when `cfg_par_even`=1 and at 1 when it is 0. A mismatch sets `err_parity`.
- R5: With `cfg_par_en`=0 no parity bit is expected, the stop bit directly follows the data, and `err_parity` is never set.
- R6: A stop-bit sample of 0 sets `err_frame`. The data bits of that word are still delivered.
- R7: If every sample of a frame reads 0 (start, data, parity if enabled, and stop), the word is reported as a break. `rx_data` becomes 0 and `err_break` is set, while `err_frame` and `err_parity` stay clear for that word.
- R8: After a break the receiver delivers nothing more until the line has returned to 1. It then waits for a new falling edge.
- R9: `rx_ready` rises only when a complete word moves into the holding register, which happens at the centre of the stop bit.
- R10: A word that completes while `rx_ready` is 1, with no data read in that cycle, sets `err_overrun` and overwrites `rx_data` with the new word.
- R11: `rd_data` clears `rx_ready`. If a word completes in the same cycle, the new word is kept, `rx_ready` stays 1 and no overrun is recorded.
- R12: The error flags accumulate over words until `rd_status` clears all four together. A flag raised by a word that completes in the same cycle as `rd_status` survives the clear.
- R13: During reset `rx_ready` and all error flags are 0 and `rx_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversample enable, 16 pulses per bit period |
| rx_line | input | 1 | Asynchronous serial line |
| cfg_len | input | 2 | Data length select, 5 + value bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | Even parity, or stick value select |
| cfg_par_stick | input | 1 | Parity bit fixed by `cfg_par_even` |
| rd_data | input | 1 | Host data-read strobe |
| rd_status | input | 1 | Host status-read strobe |
| rx_data | output | 8 | Received word, right-justified |
| rx_ready | output | 1 | Holding register holds an unread word |
| err_overrun | output | 1 | Word overwritten before it was read |
| err_parity | output | 1 | Parity mismatch seen |
| err_frame | output | 1 | Stop bit sampled as 0 |
| err_break | output | 1 | Break received |

## Verification
Two events can fall in the same cycle: a word completing into the holding register, and a host strobe (a data read or a status read). To provoke this, a probe frame is first sent to an empty buffer, and the bench measures how many cycles pass from its start edge to the rise of `rx_ready`. An identical frame is then sent with the same oversample-enable phase, and the strobe is placed exactly in its completion cycle. The result is judged at the ports. For a data read, the new word must still be marked ready with no overrun. For a status read on a word with bad parity that arrives over an unread word, the parity and overrun flags must both survive the clear.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4,
        ST_MARK  = 3'd5
    } rx_state_e;

    typedef struct packed {
        logic par_err;
        logic frm_err;
        logic brk;
    } rx_flags_t;

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;   // idle line is mark
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
    import serial_rx_pkg::*;
#(
    parameter int OS_RATE  = 16,
    parameter int MIN_BITS = 5,
    parameter int MAX_BITS = 8,
    parameter int LEN_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                line_s,
    input  logic [LEN_W-1:0]    cfg_len,
    input  logic                par_en,
    input  logic                par_even,
    input  logic                par_stick,
    output logic                word_done,
    output logic [MAX_BITS-1:0] word_data,
    output rx_flags_t           word_flags
);
    localparam int OS_W  = $clog2(OS_RATE);
    localparam int BIT_W = $clog2(MAX_BITS);
    localparam int SPAN  = MAX_BITS - MIN_BITS;
    localparam logic [OS_W-1:0] MID_PT = OS_W'(OS_RATE / 2 - 1);
    localparam logic [OS_W-1:0] END_PT = OS_W'(OS_RATE - 1);

    typedef struct packed {
        rx_state_e             st;
        logic [OS_W-1:0]       os;
        logic [BIT_W-1:0]      bits;
        logic [MAX_BITS-1:0]   sh;
        logic                  acc;
        logic                  pbit;
        logic                  allz;
        logic                  prev;
    } fsm_t;

    fsm_t d, q;
    logic [BIT_W-1:0] last_idx;
    logic             exp_par;
    logic             brk_now;

    always_comb begin
        last_idx = BIT_W'(MIN_BITS - 1) + BIT_W'(cfg_len);
        exp_par  = par_stick ? ~par_even : (par_even ? q.acc : ~q.acc);
    end

    always_comb begin
        d          = q;
        d.prev     = line_s;
        word_done  = 1'b0;
        word_flags = '0;
        brk_now    = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (q.prev && !line_s) begin
                    d.st = ST_START;
                    d.os = '0;          // realign on the edge
                end
            end
            ST_START: begin
                if (tick) begin
                    if (q.os == MID_PT) begin
                        if (line_s) begin
                            d.st = ST_IDLE;   // glitch
                        end else begin
                            d.st   = ST_DATA;
                            d.os   = '0;
                            d.bits = '0;
                            d.sh   = '0;
                            d.acc  = 1'b0;
                            d.pbit = 1'b0;
                            d.allz = 1'b1;
                        end
                    end else begin
                        d.os = q.os + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    if (q.os == END_PT) begin
                        d.os   = '0;
                        d.sh   = {line_s, q.sh[MAX_BITS-1:1]};
                        d.acc  = q.acc ^ line_s;
                        d.allz = q.allz & ~line_s;
                        if (q.bits == last_idx) d.st = par_en ? ST_PAR : ST_STOP;
                        else                    d.bits = q.bits + 1'b1;
                    end else begin
                        d.os = q.os + 1'b1;
                    end
                end
            end
            ST_PAR: begin
                if (tick) begin
                    if (q.os == END_PT) begin
                        d.os   = '0;
                        d.pbit = line_s;
                        d.allz = q.allz & ~line_s;
                        d.st   = ST_STOP;
                    end else begin
                        d.os = q.os + 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (tick) begin
                    if (q.os == END_PT) begin
                        d.os               = '0;
                        word_done          = 1'b1;
                        brk_now            = q.allz & ~line_s;
                        word_flags.brk     = brk_now;
                        word_flags.frm_err = ~line_s & ~brk_now;
                        word_flags.par_err = par_en & (q.pbit != exp_par) & ~brk_now;
                        d.st               = brk_now ? ST_MARK : ST_IDLE;
                    end else begin
                        d.os = q.os + 1'b1;
                    end
                end
            end
            ST_MARK: begin
                if (line_s) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_comb begin
        word_data = brk_now ? '0 : (q.sh >> (SPAN - int'(cfg_len)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.prev <= 1'b1;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/serial_rx_hold.sv
module serial_rx_hold
    import serial_rx_pkg::*;
#(
    parameter int MAX_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                commit,
    input  logic [MAX_BITS-1:0] new_data,
    input  rx_flags_t           new_flags,
    input  logic                rd_data,
    input  logic                rd_status,
    output logic [MAX_BITS-1:0] data_out,
    output logic                ready,
    output logic                ovr,
    output logic                perr,
    output logic                ferr,
    output logic                berr
);
    typedef struct packed {
        logic [MAX_BITS-1:0] data;
        logic                ready;
        logic                ovr;
        logic                perr;
        logic                ferr;
        logic                berr;
    } hold_t;

    hold_t d, q;

    always_comb begin
        d = q;
        if (rd_data) d.ready = 1'b0;
        if (rd_status) begin
            d.ovr  = 1'b0;
            d.perr = 1'b0;
            d.ferr = 1'b0;
            d.berr = 1'b0;
        end
        if (commit) begin
            d.data  = new_data;
            d.ready = 1'b1;
            if (q.ready && !rd_data) d.ovr = 1'b1;
            d.perr = d.perr | new_flags.par_err;
            d.ferr = d.ferr | new_flags.frm_err;
            d.berr = d.berr | new_flags.brk;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign data_out = q.data;
    assign ready    = q.ready;
    assign ovr      = q.ovr;
    assign perr     = q.perr;
    assign ferr     = q.ferr;
    assign berr     = q.berr;
endmodule

// File: rtl/serial_rx.sv
module serial_rx
    import serial_rx_pkg::*;
#(
    parameter  int OS_RATE     = 16,
    parameter  int MIN_BITS    = 5,
    parameter  int MAX_BITS    = 8,
    parameter  int SYNC_STAGES = 2,
    localparam int LEN_W       = $clog2(MAX_BITS - MIN_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                os_tick,
    input  logic                rx_line,
    input  logic [LEN_W-1:0]    cfg_len,
    input  logic                cfg_par_en,
    input  logic                cfg_par_even,
    input  logic                cfg_par_stick,
    input  logic                rd_data,
    input  logic                rd_status,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_ready,
    output logic                err_overrun,
    output logic                err_parity,
    output logic                err_frame,
    output logic                err_break
);
    logic                line_s;
    logic                word_done;
    logic [MAX_BITS-1:0] word_data;
    rx_flags_t           word_flags;

    serial_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_line),
        .dout  (line_s)
    );

    serial_rx_frame #(
        .OS_RATE  (OS_RATE),
        .MIN_BITS (MIN_BITS),
        .MAX_BITS (MAX_BITS),
        .LEN_W    (LEN_W)
    ) i_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (os_tick),
        .line_s     (line_s),
        .cfg_len    (cfg_len),
        .par_en     (cfg_par_en),
        .par_even   (cfg_par_even),
        .par_stick  (cfg_par_stick),
        .word_done  (word_done),
        .word_data  (word_data),
        .word_flags (word_flags)
    );

    serial_rx_hold #(.MAX_BITS(MAX_BITS)) i_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (word_done),
        .new_data  (word_data),
        .new_flags (word_flags),
        .rd_data   (rd_data),
        .rd_status (rd_status),
        .data_out  (rx_data),
        .ready     (rx_ready),
        .ovr       (err_overrun),
        .perr      (err_parity),
        .ferr      (err_frame),
        .berr      (err_break)
    );
endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk #(
    parameter int MAX_BITS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                commit,
    input logic                brk_in,
    input logic                frm_in,
    input logic                par_in,
    input logic                rd_data,
    input logic                rd_status,
    input logic [MAX_BITS-1:0] rx_data,
    input logic                rx_ready,
    input logic                err_overrun,
    input logic                err_parity,
    input logic                err_frame,
    input logic                err_break
);
    // R9: a finished word is always marked ready
    a_r9_ready_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> rx_ready);

    // R9: ready has no other source than a finished word
    a_r9_ready_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> $past(commit));

    // R10: unread word overwritten
    a_r10_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && rx_ready && !rd_data) |=> err_overrun);

    // R11: data read empties the buffer when nothing arrives
    a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !commit) |=> !rx_ready);

    // R12: status read clears every flag when nothing arrives
    a_r12_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !commit) |=> !(err_overrun || err_parity || err_frame || err_break));

    // R7: a break word carries no framing or parity error
    a_r7_break_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && brk_in) |-> !(frm_in || par_in));

    // R7: a break loads a zero word
    a_r7_break_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && brk_in) |=> (rx_data == '0 && err_break));
endmodule

bind serial_rx serial_rx_chk #(.MAX_BITS(MAX_BITS)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit      (word_done),
    .brk_in      (word_flags.brk),
    .frm_in      (word_flags.frm_err),
    .par_in      (word_flags.par_err),
    .rd_data     (rd_data),
    .rd_status   (rd_status),
    .rx_data     (rx_data),
    .rx_ready    (rx_ready),
    .err_overrun (err_overrun),
    .err_parity  (err_parity),
    .err_frame   (err_frame),
    .err_break   (err_break)
);

// File: tb/test_serial_rx.sv
module test_serial_rx;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CYC    = 32;     // 16 enable pulses, one every 2 clocks
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick;
    logic       rx_line = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       cfg_par_stick = 1'b0;
    logic       rd_data = 1'b0;
    logic       rd_status = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, err_overrun, err_parity, err_frame, err_break;

    int checks = 0;
    int fails  = 0;
    logic [31:0] cyc = 0;
    logic [31:0] c0 = 0;
    logic [31:0] rise_cyc = 0;
    logic        last_rdy = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign os_tick = ~cyc[0];

    always @(negedge clk) begin
        if (rx_ready && !last_rdy) rise_cyc = cyc;
        last_rdy = rx_ready;
    end

    serial_rx i_serial_rx (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
        .cfg_par_stick(cfg_par_stick), .rd_data(rd_data), .rd_status(rd_status),
        .rx_data(rx_data), .rx_ready(rx_ready), .err_overrun(err_overrun),
        .err_parity(err_parity), .err_frame(err_frame), .err_break(err_break)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // mode: 0 none, 1 even, 2 odd, 3 stick with even=1 (bit 0), 4 stick with even=0 (bit 1)
    task automatic set_cfg(input int len_bits, input int mode);
        @(negedge clk);
        cfg_len       = 2'(len_bits - 5);
        cfg_par_en    = (mode != 0);
        cfg_par_even  = (mode == 1) || (mode == 3);
        cfg_par_stick = (mode >= 3);
    endtask

    function automatic logic exp_parity(input logic [7:0] dm, input int mode);
        case (mode)
            1: return ^dm;
            2: return ~^dm;
            3: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic hold_bit(input logic v);
        rx_line = v;
        repeat (BIT_CYC) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input int nb, input int mode,
                              input logic flip, input logic stopv);
        logic [7:0] dm;
        dm = d & 8'((1 << nb) - 1);
        @(negedge clk);
        c0 = cyc;
        hold_bit(1'b0);
        for (int i = 0; i < nb; i++) hold_bit(dm[i]);
        if (mode != 0) hold_bit(exp_parity(dm, mode) ^ flip);
        hold_bit(stopv);
        hold_bit(1'b1);
    endtask

    task automatic align();
        @(negedge clk);
        while (cyc[0] != 1'b0) @(negedge clk);
    endtask

    task automatic read_all();
        @(negedge clk);
        rd_data = 1'b1; rd_status = 1'b1;
        @(negedge clk);
        rd_data = 1'b0; rd_status = 1'b0;
    endtask

    task automatic check_word(input string req, input logic [7:0] d, input logic pe,
                              input logic fe, input logic bk, input logic ov);
        check({req, " ready"},   32'(rx_ready),    32'd1);
        check({req, " data"},    32'(rx_data),     32'(d));
        check({req, " parity"},  32'(err_parity),  32'(pe));
        check({req, " frame"},   32'(err_frame),   32'(fe));
        check({req, " break"},   32'(err_break),   32'(bk));
        check({req, " overrun"}, 32'(err_overrun), 32'(ov));
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] pats [6];
        logic [31:0] dly;
        pats = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};

        repeat (3) @(negedge clk);
        // R13 reset state
        check("R13 ready", 32'(rx_ready), 0);
        check("R13 flags", 32'({err_overrun, err_parity, err_frame, err_break}), 0);
        check("R13 data", 32'(rx_data), 0);
        rst_n = 1'b1;
        repeat (BIT_CYC) @(negedge clk);

        // R1 R3 R4 R5: sweep lengths, parity modes, patterns
        for (int len = 5; len <= 8; len++) begin
            for (int mode = 0; mode <= 4; mode++) begin
                set_cfg(len, mode);
                for (int p = 0; p < 6; p++) begin
                    send_frame(pats[p], len, mode, 1'b0, 1'b1);
                    check_word(mode == 0 ? "R5 R3 sweep" : "R4 R3 R1 sweep",
                               pats[p] & 8'((1 << len) - 1), 0, 0, 0, 0);
                    read_all();
                    check("R11 ready cleared", 32'(rx_ready), 0);
                end
            end
        end

        // R4: wrong parity in every parity mode
        for (int mode = 1; mode <= 4; mode++) begin
            set_cfg(7, mode);
            send_frame(8'h4B, 7, mode, 1'b1, 1'b1);
            check_word("R4 bad parity", 8'h4B, 1, 0, 0, 0);
            read_all();
        end

        // R6: stop bit low, data still delivered
        set_cfg(8, 0);
        send_frame(8'h3C, 8, 0, 1'b0, 1'b0);
        check_word("R6 framing", 8'h3C, 0, 1, 0, 0);
        read_all();
        // R6 R7: zero data, odd parity bit 1, stop low -> framing, not break
        set_cfg(8, 2);
        send_frame(8'h00, 8, 2, 1'b0, 1'b0);
        check_word("R6 not break", 8'h00, 0, 1, 0, 0);
        read_all();

        // R7 R8: break
        set_cfg(8, 1);
        @(negedge clk);
        rx_line = 1'b0;
        repeat (24 * BIT_CYC) @(negedge clk);
        check_word("R7 break", 8'h00, 0, 0, 1, 0);
        read_all();
        repeat (12 * BIT_CYC) @(negedge clk);
        check("R8 no word while low", 32'(rx_ready), 0);
        rx_line = 1'b1;
        repeat (2 * BIT_CYC) @(negedge clk);
        send_frame(8'h5A, 8, 1, 1'b0, 1'b1);
        check_word("R8 after mark", 8'h5A, 0, 0, 0, 0);
        read_all();

        // R2: short low pulse is a glitch
        set_cfg(8, 0);
        @(negedge clk);
        rx_line = 1'b0;
        repeat (6) @(negedge clk);
        rx_line = 1'b1;
        repeat (12 * BIT_CYC) @(negedge clk);
        check("R2 glitch ready", 32'(rx_ready), 0);
        check("R2 glitch flags", 32'({err_overrun, err_parity, err_frame, err_break}), 0);
        send_frame(8'hC3, 8, 0, 1'b0, 1'b1);
        check_word("R2 after glitch", 8'hC3, 0, 0, 0, 0);
        read_all();

        // R10: overrun overwrites
        send_frame(8'h11, 8, 0, 1'b0, 1'b1);
        send_frame(8'h22, 8, 0, 1'b0, 1'b1);
        check_word("R10 overrun", 8'h22, 0, 0, 0, 1);
        read_all();
        check("R12 overrun cleared", 32'(err_overrun), 0);

        // R12: flags accumulate until status read
        set_cfg(8, 1);
        send_frame(8'h0F, 8, 1, 1'b1, 1'b1);
        @(negedge clk); rd_data = 1'b1; @(negedge clk); rd_data = 1'b0;
        send_frame(8'hF0, 8, 1, 1'b0, 1'b1);
        check_word("R12 sticky parity", 8'hF0, 1, 0, 0, 0);
        read_all();

        // R9 R11: probe completion time, then collide data read with completion
        set_cfg(8, 0);
        repeat (2 * BIT_CYC) @(negedge clk);
        align();
        send_frame(8'hA5, 8, 0, 1'b0, 1'b1);
        dly = rise_cyc - c0;
        check("R9 ready not before stop centre", 32'(dly >= 32'(9 * BIT_CYC + BIT_CYC / 2)), 1);
        check("R9 ready before frame end", 32'(dly <= 32'(10 * BIT_CYC + 8)), 1);
        align();
        fork
            send_frame(8'h3C, 8, 0, 1'b0, 1'b1);
            begin
                repeat (dly) @(negedge clk);
                rd_data = 1'b1;
                @(negedge clk);
                rd_data = 1'b0;
            end
        join
        check_word("R11 read collides", 8'h3C, 0, 0, 0, 0);
        read_all();

        // R12: status read collides with a bad-parity word arriving over an unread word
        set_cfg(8, 1);
        repeat (2 * BIT_CYC) @(negedge clk);
        align();
        send_frame(8'h96, 8, 1, 1'b0, 1'b1);
        dly = rise_cyc - c0;
        align();
        fork
            send_frame(8'h69, 8, 1, 1'b1, 1'b1);
            begin
                repeat (dly) @(negedge clk);
                rd_status = 1'b1;
                @(negedge clk);
                rd_status = 1'b0;
            end
        join
        check_word("R12 status collides", 8'h69, 1, 0, 0, 1);
        read_all();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule